// File: doc/BRIEF.md
# Shared-Memory Request Sequencer

This block sits between the execution stage of a compute unit and its on-chip shared scratchpad. Requests from the execution stage wait in an issue queue. Each cycle the oldest request can be handed to the scratchpad, but only while the return queue has room below a configured occupancy limit. A handed-over request leaves the queue whether or not the scratchpad takes it. When the scratchpad refuses it, a retry flag pulses for a separate recovery path.

Replies from the scratchpad wait in a bounded return queue. They retire in arrival order toward the register file, at most one per cycle. The head reply retires only when four conditions hold together:
- its latency has run out;
- the register-file write port is ready, which matters only for operations that return a value;
- the memory-to-register bus timer is idle;
- either co-issued returns are enabled or the timer of the issuing pipe is idle.

A retirement loads both timers with the reply's duration. It also lowers the per-wavefront outstanding counters of the request's class. The same counters rise when a request is accepted into the issue queue.

Top module: `smem_sequencer`

## Requirements
- R1: `snd_valid` is high exactly when the issue queue holds a request and the return queue holds fewer than `RET_LIMIT` entries. `snd_data` is then the oldest queued request.
- R2: A request shown on `snd_valid` leaves the issue queue at that clock edge even if `snd_accept` is low. In that cycle `snd_retry` is high.
- R3: The head reply waits one cycle per unit of its `rep_delay` before it may retire, counted from the cycle it first appears at the head. A delay of 0 allows retirement in that first cycle.
- R4: Operation kinds are encoded as 0 load, 1 store, 2 atomic without return, 3 atomic with return. Kinds 0 and 3 retire only while `rf_wr_ready` is high. Kinds 1 and 2 ignore `rf_wr_ready`.
- R5: After a retirement with duration D, no other reply retires during the next D cycles. This holds whether `coissue_en` is high or low; with `coissue_en` low the pipe timer of the retiring reply is also loaded with D.
- R6: Each (simd, slot) pair owns three counters held at bits [(simd*NUM_SLOTS+slot)*CNT_W +: CNT_W] of `cnt_total`, `cnt_write` and `cnt_read`. An accepted request raises them and a retirement lowers them. The total counter moves for every kind, the write counter for kinds 1, 2 and 3, and the read counter for kinds 0, 2 and 3. A counter at zero stays at zero when lowered.
- R7: `req_ready` is low while the issue queue holds `ISSUE_DEPTH` entries, and `rep_ready` is low while the return queue holds `RET_DEPTH` entries. A send and a retirement may happen in the same cycle.
- R8: After reset both queues are empty, all counters are zero, and `snd_valid` and `wb_grant` are low.
- R9: Replies retire in arrival order. While `wb_grant` is high, `wb_simd` and `wb_slot` name the retiring reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request enqueue strobe |
| req_ready | output | 1 | Issue queue has room |
| req_data | input | REQ_W | Request payload |
| req_simd | input | SIMD_W | SIMD of the issuing wavefront |
| req_slot | input | SLOT_W | Wavefront slot of the request |
| req_kind | input | 2 | Operation kind of the request |
| snd_valid | output | 1 | Request presented to scratchpad |
| snd_data | output | REQ_W | Payload of the presented request |
| snd_accept | input | 1 | Scratchpad takes the presented request |
| snd_retry | output | 1 | Presented request was refused |
| rep_valid | input | 1 | Reply enqueue strobe |
| rep_ready | output | 1 | Return queue has room |
| rep_simd | input | SIMD_W | SIMD of the reply |
| rep_slot | input | SLOT_W | Wavefront slot of the reply |
| rep_pipe | input | PIPE_W | Issuing pipe of the reply |
| rep_kind | input | 2 | Operation kind of the reply |
| rep_delay | input | TIME_W | Latency cycles before retirement |
| rep_dur | input | TIME_W | Bus busy duration after retirement |
| rf_wr_ready | input | 1 | Register-file write port ready |
| coissue_en | input | 1 | Co-issued returns enabled |
| wb_grant | output | 1 | Head reply retires this cycle |
| wb_simd | output | SIMD_W | SIMD of the retiring reply |
| wb_slot | output | SLOT_W | Slot of the retiring reply |
| cnt_total | output | NUM_SIMD*NUM_SLOTS*CNT_W | Total outstanding counters |
| cnt_write | output | NUM_SIMD*NUM_SLOTS*CNT_W | Write-class outstanding counters |
| cnt_read | output | NUM_SIMD*NUM_SLOTS*CNT_W | Read-class outstanding counters |

## Verification
The checks assume that `rep_kind` and `req_kind` carry one of the four encodings. They also assume that producers hold `req_valid` and `rep_valid` until the matching ready is seen. The bench drives only defined kinds and waits on ready before it drops a strobe. It also never loads a counter past its maximum, so the counter check only meets decrements from a counter above zero or held at zero. When a reply retires in the same cycle that a request to the same slot is accepted, the counter check leaves that cycle alone. The bench keeps such collisions rare.

// File: rtl/smem_seq_pkg.sv
// Shared definitions for the shared-memory sequencer.
// Assumes the two-bit operation kind encoding described in the brief.
package smem_seq_pkg;

    typedef enum logic [1:0] {
        K_LOAD       = 2'd0,
        K_STORE      = 2'd1,
        K_ATOMIC     = 2'd2,
        K_ATOMIC_RET = 2'd3
    } op_kind_e;

    // True when the kind returns data into the register file.
    function automatic logic needs_rf(input logic [1:0] k);
        return (k == K_LOAD) || (k == K_ATOMIC_RET);
    endfunction

    // True when the kind counts against the write-class counter.
    function automatic logic is_write_class(input logic [1:0] k);
        return (k != K_LOAD);
    endfunction

    // True when the kind counts against the read-class counter.
    function automatic logic is_read_class(input logic [1:0] k);
        return (k != K_STORE);
    endfunction

endpackage

// File: rtl/smem_fifo.sv
// Synchronous FIFO with occupancy count.
// Assumes the caller never pushes when full or pops when empty; both are guarded anyway.
module smem_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/smem_busy_timer.sv
// Down-counting busy timer: load sets the count, idle means the count is zero.
// Assumes load and count-down never need to be distinguished in one cycle (load wins).
module smem_busy_timer #(
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] dur,
    output logic              idle
);
    logic [TIME_W-1:0] cnt;

    assign idle = (cnt == '0);

    // Load on retirement, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= dur;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/smem_outstanding.sv
// Per-wavefront outstanding-request counters: total, write class and read class.
// Raised on accepted requests, lowered on retirements; saturate at both ends.
module smem_outstanding
    import smem_seq_pkg::*;
#(
    parameter int NUM_SIMD  = 2,
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 4,
    parameter int SIMD_W    = 1,
    parameter int SLOT_W    = 2,
    localparam int NENT     = NUM_SIMD * NUM_SLOTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_v,
    input  logic [SIMD_W-1:0]     inc_simd,
    input  logic [SLOT_W-1:0]     inc_slot,
    input  logic [1:0]            inc_kind,
    input  logic                  dec_v,
    input  logic [SIMD_W-1:0]     dec_simd,
    input  logic [SLOT_W-1:0]     dec_slot,
    input  logic [1:0]            dec_kind,
    output logic [NENT*CNT_W-1:0] total_o,
    output logic [NENT*CNT_W-1:0] write_o,
    output logic [NENT*CNT_W-1:0] read_o
);
    int unsigned inc_idx, dec_idx;
    assign inc_idx = int'(inc_simd) * NUM_SLOTS + int'(inc_slot);
    assign dec_idx = int'(dec_simd) * NUM_SLOTS + int'(dec_slot);

    // Class membership of a kind: 0 total, 1 write, 2 read.
    function automatic logic hits(input int c, input logic [1:0] k);
        if (c == 0) return 1'b1;
        if (c == 1) return is_write_class(k);
        return is_read_class(k);
    endfunction

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        for (genvar c = 0; c < 3; c++) begin : g_cls
            logic [CNT_W-1:0] cnt;
            logic up, dn;
            assign up = inc_v && (inc_idx == e) && hits(c, inc_kind);
            assign dn = dec_v && (dec_idx == e) && hits(c, dec_kind);

            // Saturating up/down step of one counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                           cnt <= '0;
                else if (up && !dn && cnt != '1)      cnt <= cnt + 1'b1;
                else if (dn && !up && cnt != '0)      cnt <= cnt - 1'b1;
            end

            if (c == 0) begin : g_t
                assign total_o[e*CNT_W +: CNT_W] = cnt;
            end else if (c == 1) begin : g_w
                assign write_o[e*CNT_W +: CNT_W] = cnt;
            end else begin : g_r
                assign read_o[e*CNT_W +: CNT_W] = cnt;
            end
        end
    end
endmodule

// File: rtl/smem_sequencer.sv
// Shared-memory request issue and reply return sequencer.
// Issues at most one request and retires at most one reply per cycle.
// Assumes producers hold their valid strobes until ready is seen.
module smem_sequencer
    import smem_seq_pkg::*;
#(
    parameter int REQ_W       = 8,
    parameter int ISSUE_DEPTH = 4,
    parameter int RET_DEPTH   = 4,
    parameter int RET_LIMIT   = 2,
    parameter int NUM_SIMD    = 2,
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_PIPES   = 2,
    parameter int CNT_W       = 4,
    parameter int TIME_W      = 4,
    localparam int SIMD_W     = (NUM_SIMD  > 1) ? $clog2(NUM_SIMD)  : 1,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int PIPE_W     = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
    localparam int NENT       = NUM_SIMD * NUM_SLOTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [REQ_W-1:0]      req_data,
    input  logic [SIMD_W-1:0]     req_simd,
    input  logic [SLOT_W-1:0]     req_slot,
    input  logic [1:0]            req_kind,
    output logic                  snd_valid,
    output logic [REQ_W-1:0]      snd_data,
    input  logic                  snd_accept,
    output logic                  snd_retry,
    input  logic                  rep_valid,
    output logic                  rep_ready,
    input  logic [SIMD_W-1:0]     rep_simd,
    input  logic [SLOT_W-1:0]     rep_slot,
    input  logic [PIPE_W-1:0]     rep_pipe,
    input  logic [1:0]            rep_kind,
    input  logic [TIME_W-1:0]     rep_delay,
    input  logic [TIME_W-1:0]     rep_dur,
    input  logic                  rf_wr_ready,
    input  logic                  coissue_en,
    output logic                  wb_grant,
    output logic [SIMD_W-1:0]     wb_simd,
    output logic [SLOT_W-1:0]     wb_slot,
    output logic [NENT*CNT_W-1:0] cnt_total,
    output logic [NENT*CNT_W-1:0] cnt_write,
    output logic [NENT*CNT_W-1:0] cnt_read
);
    // Reply record layout: {simd, slot, pipe, kind, delay, dur}.
    localparam int O_DUR   = 0;
    localparam int O_DELAY = O_DUR + TIME_W;
    localparam int O_KIND  = O_DELAY + TIME_W;
    localparam int O_PIPE  = O_KIND + 2;
    localparam int O_SLOT  = O_PIPE + PIPE_W;
    localparam int O_SIMD  = O_SLOT + SLOT_W;
    localparam int REP_W   = O_SIMD + SIMD_W;
    localparam int ICW     = $clog2(ISSUE_DEPTH + 1);
    localparam int RCW     = $clog2(RET_DEPTH + 1);

    // ---------------- issue side ----------------
    logic             iss_full, iss_empty;
    logic [ICW-1:0]   iss_count;
    logic             req_push;

    assign req_ready = !iss_full;
    assign req_push  = req_valid && req_ready;

    smem_fifo #(.W(REQ_W), .DEPTH(ISSUE_DEPTH)) u_issue_q (
        .clk(clk), .rst_n(rst_n),
        .push(req_push), .din(req_data),
        .pop(snd_valid), .dout(snd_data),
        .full(iss_full), .empty(iss_empty), .count(iss_count)
    );

    // ---------------- return side ----------------
    logic             ret_full, ret_empty;
    logic [RCW-1:0]   ret_count;
    logic [REP_W-1:0] rep_word, head;
    logic             retire;

    assign rep_ready = !ret_full;
    assign rep_word  = {rep_simd, rep_slot, rep_pipe, rep_kind, rep_delay, rep_dur};

    smem_fifo #(.W(REP_W), .DEPTH(RET_DEPTH)) u_return_q (
        .clk(clk), .rst_n(rst_n),
        .push(rep_valid && rep_ready), .din(rep_word),
        .pop(retire), .dout(head),
        .full(ret_full), .empty(ret_empty), .count(ret_count)
    );

    // Send gate: a request moves out only while the return queue is below its limit.
    assign snd_valid = !iss_empty && (int'(ret_count) < RET_LIMIT);
    assign snd_retry = snd_valid && !snd_accept;

    logic [TIME_W-1:0] head_dur, head_delay;
    logic [1:0]        head_kind;
    logic [PIPE_W-1:0] head_pipe;
    assign head_dur   = head[O_DUR   +: TIME_W];
    assign head_delay = head[O_DELAY +: TIME_W];
    assign head_kind  = head[O_KIND  +: 2];
    assign head_pipe  = head[O_PIPE  +: PIPE_W];
    assign wb_slot    = head[O_SLOT  +: SLOT_W];
    assign wb_simd    = head[O_SIMD  +: SIMD_W];

    // Latency tracking: cycles the current head has waited.
    logic [TIME_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || retire || ret_empty) lat_cnt <= '0;
        else if (lat_cnt != '1)            lat_cnt <= lat_cnt + 1'b1;
    end

    // Bus and per-pipe busy timers.
    logic                 bus_idle;
    logic [NUM_PIPES-1:0] pipe_idle;

    smem_busy_timer #(.TIME_W(TIME_W)) u_bus_timer (
        .clk(clk), .rst_n(rst_n), .load(retire), .dur(head_dur), .idle(bus_idle)
    );

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        smem_busy_timer #(.TIME_W(TIME_W)) u_pipe_timer (
            .clk(clk), .rst_n(rst_n),
            .load(retire && !coissue_en && (int'(head_pipe) == p)),
            .dur(head_dur), .idle(pipe_idle[p])
        );
    end

    // Retirement gate: all four conditions together.
    logic lat_ok, rf_ok, pipe_ok;
    assign lat_ok   = (lat_cnt >= head_delay);
    assign rf_ok    = !needs_rf(head_kind) || rf_wr_ready;
    assign pipe_ok  = coissue_en || pipe_idle[head_pipe];
    assign retire   = !ret_empty && lat_ok && rf_ok && bus_idle && pipe_ok;
    assign wb_grant = retire;

    // ---------------- outstanding counters ----------------
    smem_outstanding #(
        .NUM_SIMD(NUM_SIMD), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W),
        .SIMD_W(SIMD_W), .SLOT_W(SLOT_W)
    ) u_counters (
        .clk(clk), .rst_n(rst_n),
        .inc_v(req_push), .inc_simd(req_simd), .inc_slot(req_slot), .inc_kind(req_kind),
        .dec_v(retire), .dec_simd(wb_simd), .dec_slot(wb_slot), .dec_kind(head_kind),
        .total_o(cnt_total), .write_o(cnt_write), .read_o(cnt_read)
    );
endmodule

// File: rtl/smem_sequencer_chk.sv
// Assertion checker for smem_sequencer, attached by bind below.
// Assumes kinds are one of the four defined encodings.
module smem_sequencer_chk #(
    parameter int RET_LIMIT = 2,
    parameter int RET_DEPTH = 4,
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 4,
    parameter int NENT      = 8,
    parameter int SIMD_W    = 1,
    parameter int SLOT_W    = 2,
    parameter int TIME_W    = 4,
    parameter int RCW       = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  snd_valid,
    input logic [RCW-1:0]        ret_count,
    input logic                  wb_grant,
    input logic [1:0]            head_kind,
    input logic                  rf_wr_ready,
    input logic [TIME_W-1:0]     head_dur,
    input logic                  rep_ready,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [SIMD_W-1:0]     req_simd,
    input logic [SLOT_W-1:0]     req_slot,
    input logic [SIMD_W-1:0]     wb_simd,
    input logic [SLOT_W-1:0]     wb_slot,
    input logic [NENT*CNT_W-1:0] cnt_total
);
    int unsigned gidx, ridx;
    assign gidx = int'(wb_simd) * NUM_SLOTS + int'(wb_slot);
    assign ridx = int'(req_simd) * NUM_SLOTS + int'(req_slot);

    // Record the counter value expected one cycle after a plain decrement.
    logic             arm;
    int unsigned      arm_idx;
    logic [CNT_W-1:0] arm_exp;
    logic [CNT_W-1:0] cur_at_g, now_at_arm;
    assign cur_at_g   = cnt_total[gidx*CNT_W +: CNT_W];
    assign now_at_arm = cnt_total[arm_idx*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm     <= 1'b0;
            arm_idx <= 0;
            arm_exp <= '0;
        end else begin
            arm     <= wb_grant && cur_at_g != '0 && !(req_valid && req_ready && ridx == gidx);
            arm_idx <= gidx;
            arm_exp <= cur_at_g - 1'b1;
        end
    end

    AST_SEND_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        snd_valid |-> (int'(ret_count) < RET_LIMIT)); // R1

    AST_RF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_grant && (head_kind == 2'd0 || head_kind == 2'd3)) |-> rf_wr_ready); // R4

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_grant && head_dur != '0) |=> !wb_grant); // R5

    AST_TOTAL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (now_at_arm == arm_exp)); // R6

    AST_RET_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ret_count) == RET_DEPTH) |-> !rep_ready); // R7
endmodule

bind smem_sequencer smem_sequencer_chk #(
    .RET_LIMIT(RET_LIMIT), .RET_DEPTH(RET_DEPTH), .NUM_SLOTS(NUM_SLOTS),
    .CNT_W(CNT_W), .NENT(NENT), .SIMD_W(SIMD_W), .SLOT_W(SLOT_W),
    .TIME_W(TIME_W), .RCW(RCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .ret_count(ret_count),
    .wb_grant(wb_grant), .head_kind(head_kind), .rf_wr_ready(rf_wr_ready),
    .head_dur(head_dur), .rep_ready(rep_ready), .req_valid(req_valid),
    .req_ready(req_ready), .req_simd(req_simd), .req_slot(req_slot),
    .wb_simd(wb_simd), .wb_slot(wb_slot), .cnt_total(cnt_total)
);

// File: tb/tb_smem_sequencer.sv
`timescale 1ns/100ps
// Scoreboard bench: reply driver pushes expected retirements, a monitor compares grants.
module tb_smem_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [7:0]  req_data = 0;
    logic        req_simd = 0;
    logic [1:0]  req_slot = 0;
    logic [1:0]  req_kind = 0;
    logic        snd_valid;
    logic [7:0]  snd_data;
    logic        snd_accept = 1;
    logic        snd_retry;
    logic        rep_valid = 0;
    logic        rep_ready;
    logic        rep_simd = 0;
    logic [1:0]  rep_slot = 0;
    logic        rep_pipe = 0;
    logic [1:0]  rep_kind = 0;
    logic [3:0]  rep_delay = 0;
    logic [3:0]  rep_dur = 0;
    logic        rf_wr_ready = 0;
    logic        coissue_en = 1;
    logic        wb_grant;
    logic        wb_simd;
    logic [1:0]  wb_slot;
    logic [31:0] cnt_total, cnt_write, cnt_read;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_g = -100, prev_g = -100, last_dur = 0;
    logic [6:0] exp_q[$];

    always #2.5 clk = ~clk;

    smem_sequencer dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .req_simd(req_simd), .req_slot(req_slot), .req_kind(req_kind),
        .snd_valid(snd_valid), .snd_data(snd_data), .snd_accept(snd_accept),
        .snd_retry(snd_retry),
        .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_simd(rep_simd),
        .rep_slot(rep_slot), .rep_pipe(rep_pipe), .rep_kind(rep_kind),
        .rep_delay(rep_delay), .rep_dur(rep_dur),
        .rf_wr_ready(rf_wr_ready), .coissue_en(coissue_en),
        .wb_grant(wb_grant), .wb_simd(wb_simd), .wb_slot(wb_slot),
        .cnt_total(cnt_total), .cnt_write(cnt_write), .cnt_read(cnt_read)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cnt_of(input logic [31:0] v, input int s, input int sl);
        return int'(v[(s*4+sl)*4 +: 4]);
    endfunction

    task automatic check_cnt(input string tag, input int s, input int sl,
                             input int t, input int w, input int r);
        chk(cnt_of(cnt_total, s, sl) == t, {tag, " total"}, cnt_of(cnt_total, s, sl), t);
        chk(cnt_of(cnt_write, s, sl) == w, {tag, " write"}, cnt_of(cnt_write, s, sl), w);
        chk(cnt_of(cnt_read,  s, sl) == r, {tag, " read"},  cnt_of(cnt_read,  s, sl), r);
    endtask

    // Driver: enqueue one reply and record its expected retirement.
    task automatic push_rep(input int s, input int sl, input int p, input int k,
                            input int d, input int du);
        @(posedge clk); #1;
        rep_valid = 1; rep_simd = s[0]; rep_slot = sl[1:0]; rep_pipe = p[0];
        rep_kind = k[1:0]; rep_delay = d[3:0]; rep_dur = du[3:0];
        while (!rep_ready) begin @(posedge clk); #1; end
        exp_q.push_back({s[0], sl[1:0], du[3:0]});
        @(posedge clk); #1;
        rep_valid = 0;
    endtask

    task automatic push_req(input int s, input int sl, input int k, input int data);
        @(posedge clk); #1;
        req_valid = 1; req_simd = s[0]; req_slot = sl[1:0]; req_kind = k[1:0];
        req_data = data[7:0];
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_grant(output int k);
        k = 0;
        @(negedge clk);
        while (!wb_grant && k < 50) begin k++; @(negedge clk); end
    endtask

    task automatic finish_report();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare each retirement against the scoreboard and check bus spacing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && wb_grant) begin
            logic [6:0] e;
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected grant", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk({wb_simd, wb_slot} == e[6:4], "R9 retire order",
                    int'({wb_simd, wb_slot}), int'(e[6:4]));
                chk(cyc - last_g >= last_dur + 1, "R5 bus spacing", cyc - last_g, last_dur + 1);
                prev_g = last_g; last_g = cyc; last_dur = int'(e[3:0]);
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(0, "watchdog expired", 0, 1);
        finish_report();
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R8: reset state
        chk(!snd_valid && !wb_grant, "R8 idle outputs", int'({snd_valid, wb_grant}), 0);
        chk(req_ready && rep_ready, "R8 queues empty", int'({req_ready, rep_ready}), 3);
        chk(cnt_total == 0 && cnt_write == 0 && cnt_read == 0, "R8 counters zero",
            int'(cnt_total | cnt_write | cnt_read), 0);

        // Two loads stall while the register-file port is not ready (R4).
        push_rep(0, 1, 0, 0, 0, 0);
        push_rep(1, 3, 1, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(!wb_grant, "R4 load blocked by rf", int'(wb_grant), 0);

        // Requests pile up: return queue is at its limit (R1), issue queue fills (R7).
        push_req(0, 1, 0, 8'h10);
        push_req(0, 1, 1, 8'h11);
        push_req(1, 3, 2, 8'h12);
        push_req(1, 3, 3, 8'h13);
        @(negedge clk);
        chk(!snd_valid, "R1 send held at limit", int'(snd_valid), 0);
        chk(!req_ready, "R7 issue queue full", int'(req_ready), 0);
        check_cnt("R6 after enqueue s0", 0, 1, 2, 1, 1);
        check_cnt("R6 after enqueue s7", 1, 3, 2, 2, 2);

        // Release the loads, refuse the first send.
        @(posedge clk); #1;
        snd_accept = 0; rf_wr_ready = 1;
        @(negedge clk);
        while (!snd_valid && cyc < 100000) @(negedge clk);
        chk(snd_data == 8'h10, "R1 oldest request sent", int'(snd_data), 16);
        chk(snd_retry, "R2 retry on refusal", int'(snd_retry), 1);
        chk(wb_grant, "R7 send and retire together", int'(wb_grant), 1);
        @(negedge clk);
        chk(snd_data == 8'h11, "R2 refused request removed", int'(snd_data), 17);
        @(posedge clk); #1 snd_accept = 1;
        repeat (8) @(negedge clk);
        check_cnt("R6 after load retire s0", 0, 1, 1, 1, 0);
        check_cnt("R6 after load retire s7", 1, 3, 1, 2, 1);

        // R4: a store retires without the register-file port; R3 delay 0.
        @(posedge clk); #1 rf_wr_ready = 0;
        push_rep(0, 1, 0, 1, 0, 0);
        // push_rep returns one cycle after capture: the grant came already at capture+0
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R4 store ignores rf port", exp_q.size(), 0);
        check_cnt("R6 store retire", 0, 1, 0, 0, 0);

        // R6: saturation at zero.
        push_rep(0, 1, 0, 1, 0, 0);
        repeat (2) @(negedge clk);
        check_cnt("R6 saturate at zero", 0, 1, 0, 0, 0);

        // R3: latency of 3 cycles on an atomic without return.
        push_rep(1, 3, 0, 2, 3, 0);
        wait_grant(k);
        chk(k == 3, "R3 latency wait", k, 3);
        repeat (2) @(negedge clk);
        check_cnt("R6 atomic retire", 1, 3, 0, 1, 0);

        // R5: bus busy with co-issue enabled.
        push_rep(1, 0, 0, 1, 0, 4);
        push_rep(1, 0, 1, 1, 0, 4);
        repeat (12) @(negedge clk);
        chk(last_g - prev_g == 5, "R5 bus gap coissue on", last_g - prev_g, 5);

        // R5: same pipe with co-issue disabled.
        @(posedge clk); #1 coissue_en = 0;
        push_rep(0, 2, 1, 1, 0, 2);
        push_rep(0, 2, 1, 1, 0, 2);
        repeat (10) @(negedge clk);
        chk(last_g - prev_g == 3, "R5 bus gap coissue off", last_g - prev_g, 3);

        // R7: return queue back-pressure.
        @(posedge clk); #1 rf_wr_ready = 0; coissue_en = 1;
        push_rep(0, 2, 0, 0, 0, 0);
        push_rep(0, 2, 0, 0, 0, 0);
        push_rep(0, 2, 0, 0, 0, 0);
        push_rep(0, 2, 0, 0, 0, 0);
        @(negedge clk);
        chk(!rep_ready, "R7 return queue full", int'(rep_ready), 0);
        @(posedge clk); #1 rf_wr_ready = 1;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all replies retired", exp_q.size(), 0);
        chk(!snd_valid, "R1 issue queue drained", int'(snd_valid), 0);
        finish_report();
    end
endmodule